// File: doc/BRIEF.md
# Guest TLB random-write unit

This block keeps a small, fully associative translation buffer for a guest context and carries out the write-random command on it. When the command strobe arrives, the block builds one translation entry from four staging inputs: an entry-high word, two entry-low words (one per even/odd page half) and a page-mask word. It then stores that entry in the slot named by the random index input. The entry is not copied bit for bit. Both global bits are folded into one. The page-number fields are cleared under the page mask. Any other live entry that would overlap the new one is invalidated in the same clock edge, and no fault is raised for it.

Two checks guard the command. If coprocessor-0 access is off, or the command comes from guest-kernel mode, nothing is written and an exception code is reported instead. The buffer can be split into a variable-page-size region (the low slots) and a fixed-page-size region. An entry whose mask differs from the fixed page size is steered into the variable region. A combinational probe port reports which slot matches a given address and tag. A combinational read port returns the stored fields of any slot.

Top module: `gtlb_rand_wr`

## Requirements
- R1: The written slot is `rand_idx` when `pmask` equals the fixed page mask (default 0). Otherwise it is `rand_idx` modulo `VAR_SLOTS` (default 4 of 8 slots), which selects a slot in the low variable-size region.
- R2: The stored global bit is the AND of bit 0 of `elo0` and bit 0 of `elo1`. Each entry-low input is laid out as {PFN, C[2:0], D, V, G} with G at bit 0.
- R3: The stored VPN2 and both stored PFNs have cleared every low-order bit that is set in `pmask`.
- R4: The stored mask, R, ASID and each half's C, D and V equal the corresponding inputs. Each stored half is read back as {PFN, C[2:0], D, V} with V at bit 0.
- R5: When `inv_level` is 2 or more, the stored hardware-invalid flag takes the value of `ehi_hinv`. Below 2, the slot's previous flag is kept.
- R6: When `gid_en` is 1, the stored guest ID is `root_gid`. When it is 0, the slot's previous guest ID is kept.
- R7: A strobe with `cp0_en` low changes no stored state, gives no done pulse, and reports exception code 1.
- R8: A strobe with `cp0_en` high and `guest_kernel` high changes no stored state, gives no done pulse, and reports exception code 2.
- R9: During a permitted write, every other live slot that duplicates the new entry gets both V bits cleared and its hardware-invalid flag set, and no exception is raised. A slot is live when either V bit is set and its hardware-invalid flag is clear. A duplicate has equal VPN2 outside the union of both masks, equal R, and either equal ASID and guest ID or a global bit set in either entry.
- R10: `wr_done` or `exc_valid` is high for exactly one cycle, the cycle after the strobe edge, and never both at once. When `exc_valid` is low, `exc_code` is 0.
- R11: `lk_hit` is high when some live slot matches the probe. A match means equal VPN2 outside that slot's mask, equal R, and either the slot's global bit or equal ASID and guest ID. `lk_idx` is the lowest such slot.
- R12: After reset, every slot reads as all zeros, and `wr_done`, `exc_valid` and `lk_hit` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Write-random command strobe |
| cp0_en | input | 1 | Coprocessor-0 access enabled |
| guest_kernel | input | 1 | Command issued from guest-kernel mode |
| inv_level | input | 2 | Invalidate-support level |
| gid_en | input | 1 | Guest-ID storage enable |
| root_gid | input | GID_W | Current root guest ID |
| ehi_vpn2 | input | VPN2_W | Entry-high virtual page pair number |
| ehi_r | input | R_W | Entry-high region |
| ehi_asid | input | ASID_W | Entry-high address-space ID |
| ehi_hinv | input | 1 | Entry-high hardware-invalid request |
| elo0 | input | PFN_W+6 | Even half {PFN, C, D, V, G} |
| elo1 | input | PFN_W+6 | Odd half {PFN, C, D, V, G} |
| pmask | input | MASK_W | Page mask |
| rand_idx | input | IDX_W | Random slot index |
| wr_done | output | 1 | Write completed pulse |
| exc_valid | output | 1 | Exception pulse |
| exc_code | output | 2 | 0 none, 1 coprocessor unusable, 2 reserved instruction |
| lk_vpn2 | input | VPN2_W | Probe VPN2 |
| lk_r | input | R_W | Probe region |
| lk_asid | input | ASID_W | Probe ASID |
| lk_gid | input | GID_W | Probe guest ID |
| lk_hit | output | 1 | Probe matched a live slot |
| lk_idx | output | IDX_W | Lowest matching slot |
| rd_idx | input | IDX_W | Read-port slot select |
| rd_vpn2 | output | VPN2_W | Stored VPN2 |
| rd_mask | output | MASK_W | Stored mask |
| rd_r | output | R_W | Stored region |
| rd_asid | output | ASID_W | Stored ASID |
| rd_gid | output | GID_W | Stored guest ID |
| rd_g | output | 1 | Stored global bit |
| rd_hinv | output | 1 | Stored hardware-invalid flag |
| rd_lo0 | output | PFN_W+5 | Stored even half {PFN, C, D, V} |
| rd_lo1 | output | PFN_W+5 | Stored odd half {PFN, C, D, V} |

## Verification
Every stored field, the duplicate invalidation and the done or exception pulse become visible exactly one clock edge after the edge that samples the strobe. The probe and read ports follow stored state without delay. The bench drives inputs and the strobe on falling edges and reads results on the falling edge after that one rising edge. It then checks, one falling edge later, that the pulse has dropped. Probe and read results are taken a short settle delay after the select inputs change. Entry formation is swept over every slot index and every page mask, with the expected slot and fields computed arithmetically.

// File: rtl/gtlb_pkg.sv
package gtlb_pkg;

  typedef enum logic [1:0] {
    EXC_NONE         = 2'd0,
    EXC_CPU_UNUSABLE = 2'd1,
    EXC_RESERVED     = 2'd2
  } exc_code_e;

  // Lowest invalidate-support level that carries a hardware-invalid flag.
  localparam logic [1:0] INV_LVL_HW = 2'd2;

endpackage

// File: rtl/gtlb_entry_form.sv
module gtlb_entry_form #(
  parameter int VPN2_W = 8,
  parameter int PFN_W  = 8,
  parameter int MASK_W = 4,
  parameter int ASID_W = 4,
  parameter int GID_W  = 3,
  parameter int R_W    = 2,
  localparam int ELO_W = PFN_W + 6,
  localparam int SLO_W = PFN_W + 5
) (
  input  logic [VPN2_W-1:0] ehi_vpn2,
  input  logic [R_W-1:0]    ehi_r,
  input  logic [ASID_W-1:0] ehi_asid,
  input  logic              ehi_hinv,
  input  logic [ELO_W-1:0]  elo0,
  input  logic [ELO_W-1:0]  elo1,
  input  logic [MASK_W-1:0] pmask,
  input  logic [1:0]        inv_level,
  input  logic              gid_en,
  input  logic [GID_W-1:0]  root_gid,
  input  logic [GID_W-1:0]  old_gid,
  input  logic              old_hinv,
  output logic [VPN2_W-1:0] f_vpn2,
  output logic [MASK_W-1:0] f_mask,
  output logic [R_W-1:0]    f_r,
  output logic [ASID_W-1:0] f_asid,
  output logic [GID_W-1:0]  f_gid,
  output logic              f_g,
  output logic              f_hinv,
  output logic [SLO_W-1:0]  f_lo0,
  output logic [SLO_W-1:0]  f_lo1
);
  import gtlb_pkg::*;

  logic [VPN2_W-1:0] vpn_clr;
  logic [PFN_W-1:0]  pfn_clr;

  // Widen the page mask onto the low-order bits of each page-number field.
  always_comb begin
    vpn_clr = '0;
    pfn_clr = '0;
    vpn_clr[MASK_W-1:0] = pmask;
    pfn_clr[MASK_W-1:0] = pmask;
  end

  always_comb begin
    f_vpn2 = ehi_vpn2 & ~vpn_clr;
    f_mask = pmask;
    f_r    = ehi_r;
    f_asid = ehi_asid;
    f_g    = elo0[0] & elo1[0];
    f_lo0  = {elo0[ELO_W-1:6] & ~pfn_clr, elo0[5:1]};
    f_lo1  = {elo1[ELO_W-1:6] & ~pfn_clr, elo1[5:1]};
    f_hinv = old_hinv;
    if (inv_level >= INV_LVL_HW) begin
      f_hinv = ehi_hinv;
    end
    f_gid  = gid_en ? root_gid : old_gid;
  end

endmodule

// File: rtl/gtlb_dup_detect.sv
module gtlb_dup_detect #(
  parameter int NUM_SLOTS = 8,
  parameter int VPN2_W    = 8,
  parameter int MASK_W    = 4,
  parameter int ASID_W    = 4,
  parameter int GID_W     = 3,
  parameter int R_W       = 2,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic [VPN2_W-1:0]                 f_vpn2,
  input  logic [MASK_W-1:0]                 f_mask,
  input  logic [R_W-1:0]                    f_r,
  input  logic [ASID_W-1:0]                 f_asid,
  input  logic [GID_W-1:0]                  f_gid,
  input  logic                              f_g,
  input  logic [IDX_W-1:0]                  tgt,
  input  logic [NUM_SLOTS-1:0][VPN2_W-1:0]  st_vpn2,
  input  logic [NUM_SLOTS-1:0][MASK_W-1:0]  st_mask,
  input  logic [NUM_SLOTS-1:0][R_W-1:0]     st_r,
  input  logic [NUM_SLOTS-1:0][ASID_W-1:0]  st_asid,
  input  logic [NUM_SLOTS-1:0][GID_W-1:0]   st_gid,
  input  logic [NUM_SLOTS-1:0]              st_g,
  input  logic [NUM_SLOTS-1:0]              st_live,
  output logic [NUM_SLOTS-1:0]              dup
);

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    logic [VPN2_W-1:0] ign;
    logic              page_eq;
    logic              tag_eq;

    // Ignore every VPN2 bit that either the new or the resident mask covers.
    always_comb begin
      ign = '0;
      ign[MASK_W-1:0] = f_mask | st_mask[k];
      page_eq = ((f_vpn2 & ~ign) == (st_vpn2[k] & ~ign)) && (f_r == st_r[k]);
      tag_eq  = f_g || st_g[k] || ((f_asid == st_asid[k]) && (f_gid == st_gid[k]));
      dup[k]  = st_live[k] && page_eq && tag_eq && (tgt != IDX_W'(k));
    end
  end

endmodule

// File: rtl/gtlb_lookup.sv
module gtlb_lookup #(
  parameter int NUM_SLOTS = 8,
  parameter int VPN2_W    = 8,
  parameter int MASK_W    = 4,
  parameter int ASID_W    = 4,
  parameter int GID_W     = 3,
  parameter int R_W       = 2,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic [VPN2_W-1:0]                 lk_vpn2,
  input  logic [R_W-1:0]                    lk_r,
  input  logic [ASID_W-1:0]                 lk_asid,
  input  logic [GID_W-1:0]                  lk_gid,
  input  logic [NUM_SLOTS-1:0][VPN2_W-1:0]  st_vpn2,
  input  logic [NUM_SLOTS-1:0][MASK_W-1:0]  st_mask,
  input  logic [NUM_SLOTS-1:0][R_W-1:0]     st_r,
  input  logic [NUM_SLOTS-1:0][ASID_W-1:0]  st_asid,
  input  logic [NUM_SLOTS-1:0][GID_W-1:0]   st_gid,
  input  logic [NUM_SLOTS-1:0]              st_g,
  input  logic [NUM_SLOTS-1:0]              st_live,
  output logic                              lk_hit,
  output logic [IDX_W-1:0]                  lk_idx
);

  logic [NUM_SLOTS-1:0] hit;

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_cmp
    logic [VPN2_W-1:0] ign;
    always_comb begin
      ign = '0;
      ign[MASK_W-1:0] = st_mask[k];
      hit[k] = st_live[k]
            && ((lk_vpn2 & ~ign) == (st_vpn2[k] & ~ign))
            && (lk_r == st_r[k])
            && (st_g[k] || ((lk_asid == st_asid[k]) && (lk_gid == st_gid[k])));
    end
  end

  // Lowest-numbered matching slot wins.
  always_comb begin
    lk_hit = 1'b0;
    lk_idx = '0;
    for (int k = NUM_SLOTS - 1; k >= 0; k--) begin
      if (hit[k]) begin
        lk_hit = 1'b1;
        lk_idx = IDX_W'(k);
      end
    end
  end

  always_comb begin
    if (lk_hit) begin
      p_hit_idx_r11: assert (hit[lk_idx] && ((hit & ((NUM_SLOTS'(1) << lk_idx) - NUM_SLOTS'(1))) == '0));
    end
  end

endmodule

// File: rtl/gtlb_rand_wr.sv
module gtlb_rand_wr #(
  parameter int NUM_SLOTS = 8,
  parameter int VAR_SLOTS = 4,
  parameter int VPN2_W    = 8,
  parameter int PFN_W     = 8,
  parameter int MASK_W    = 4,
  parameter int ASID_W    = 4,
  parameter int GID_W     = 3,
  parameter int R_W       = 2,
  parameter logic [MASK_W-1:0] FIXED_MASK = '0,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int ELO_W    = PFN_W + 6,
  localparam int SLO_W    = PFN_W + 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic              cp0_en,
  input  logic              guest_kernel,
  input  logic [1:0]        inv_level,
  input  logic              gid_en,
  input  logic [GID_W-1:0]  root_gid,
  input  logic [VPN2_W-1:0] ehi_vpn2,
  input  logic [R_W-1:0]    ehi_r,
  input  logic [ASID_W-1:0] ehi_asid,
  input  logic              ehi_hinv,
  input  logic [ELO_W-1:0]  elo0,
  input  logic [ELO_W-1:0]  elo1,
  input  logic [MASK_W-1:0] pmask,
  input  logic [IDX_W-1:0]  rand_idx,
  output logic              wr_done,
  output logic              exc_valid,
  output logic [1:0]        exc_code,
  input  logic [VPN2_W-1:0] lk_vpn2,
  input  logic [R_W-1:0]    lk_r,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [GID_W-1:0]  lk_gid,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_idx,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [VPN2_W-1:0] rd_vpn2,
  output logic [MASK_W-1:0] rd_mask,
  output logic [R_W-1:0]    rd_r,
  output logic [ASID_W-1:0] rd_asid,
  output logic [GID_W-1:0]  rd_gid,
  output logic              rd_g,
  output logic              rd_hinv,
  output logic [SLO_W-1:0]  rd_lo0,
  output logic [SLO_W-1:0]  rd_lo1
);
  import gtlb_pkg::*;

  // Stored buffer, one field array per entry field.
  logic [NUM_SLOTS-1:0][VPN2_W-1:0] st_vpn2, nx_vpn2;
  logic [NUM_SLOTS-1:0][MASK_W-1:0] st_mask, nx_mask;
  logic [NUM_SLOTS-1:0][R_W-1:0]    st_r,    nx_r;
  logic [NUM_SLOTS-1:0][ASID_W-1:0] st_asid, nx_asid;
  logic [NUM_SLOTS-1:0][GID_W-1:0]  st_gid,  nx_gid;
  logic [NUM_SLOTS-1:0]             st_g,    nx_g;
  logic [NUM_SLOTS-1:0]             st_hinv, nx_hinv;
  logic [NUM_SLOTS-1:0][SLO_W-1:0]  st_lo0,  nx_lo0;
  logic [NUM_SLOTS-1:0][SLO_W-1:0]  st_lo1,  nx_lo1;
  logic [NUM_SLOTS-1:0]             st_live;
  logic [NUM_SLOTS-1:0]             dup;

  logic [IDX_W-1:0]  tgt;
  logic              wr_go;
  exc_code_e         exc_nx, exc_q;
  logic              done_q;

  logic [VPN2_W-1:0] f_vpn2;
  logic [MASK_W-1:0] f_mask;
  logic [R_W-1:0]    f_r;
  logic [ASID_W-1:0] f_asid;
  logic [GID_W-1:0]  f_gid;
  logic              f_g;
  logic              f_hinv;
  logic [SLO_W-1:0]  f_lo0;
  logic [SLO_W-1:0]  f_lo1;

  // ---------------------------------------------------------------- target
  if (VAR_SLOTS < NUM_SLOTS) begin : g_split
    localparam int VAR_IW = $clog2(VAR_SLOTS);
    always_comb begin
      tgt = rand_idx;
      if (pmask != FIXED_MASK) begin
        tgt = '0;
        tgt[VAR_IW-1:0] = rand_idx[VAR_IW-1:0];
      end
    end
  end else begin : g_flat
    assign tgt = rand_idx;
  end

  // ---------------------------------------------------------------- checks
  always_comb begin
    exc_nx = EXC_NONE;
    if (wr_req) begin
      if (!cp0_en) begin
        exc_nx = EXC_CPU_UNUSABLE;
      end else if (guest_kernel) begin
        exc_nx = EXC_RESERVED;
      end
    end
  end

  assign wr_go = wr_req && cp0_en && !guest_kernel;

  // ---------------------------------------------------------------- live map
  always_comb begin
    for (int k = 0; k < NUM_SLOTS; k++) begin
      st_live[k] = (st_lo0[k][0] || st_lo1[k][0]) && !st_hinv[k];
    end
  end

  // ---------------------------------------------------------------- entry build
  gtlb_entry_form #(
    .VPN2_W (VPN2_W), .PFN_W (PFN_W), .MASK_W (MASK_W),
    .ASID_W (ASID_W), .GID_W (GID_W), .R_W    (R_W)
  ) u_form (
    .ehi_vpn2  (ehi_vpn2),
    .ehi_r     (ehi_r),
    .ehi_asid  (ehi_asid),
    .ehi_hinv  (ehi_hinv),
    .elo0      (elo0),
    .elo1      (elo1),
    .pmask     (pmask),
    .inv_level (inv_level),
    .gid_en    (gid_en),
    .root_gid  (root_gid),
    .old_gid   (st_gid[tgt]),
    .old_hinv  (st_hinv[tgt]),
    .f_vpn2    (f_vpn2),
    .f_mask    (f_mask),
    .f_r       (f_r),
    .f_asid    (f_asid),
    .f_gid     (f_gid),
    .f_g       (f_g),
    .f_hinv    (f_hinv),
    .f_lo0     (f_lo0),
    .f_lo1     (f_lo1)
  );

  // ---------------------------------------------------------------- duplicates
  gtlb_dup_detect #(
    .NUM_SLOTS (NUM_SLOTS), .VPN2_W (VPN2_W), .MASK_W (MASK_W),
    .ASID_W    (ASID_W),    .GID_W  (GID_W),  .R_W    (R_W)
  ) u_dup (
    .f_vpn2  (f_vpn2),
    .f_mask  (f_mask),
    .f_r     (f_r),
    .f_asid  (f_asid),
    .f_gid   (f_gid),
    .f_g     (f_g),
    .tgt     (tgt),
    .st_vpn2 (st_vpn2),
    .st_mask (st_mask),
    .st_r    (st_r),
    .st_asid (st_asid),
    .st_gid  (st_gid),
    .st_g    (st_g),
    .st_live (st_live),
    .dup     (dup)
  );

  // ---------------------------------------------------------------- probe
  gtlb_lookup #(
    .NUM_SLOTS (NUM_SLOTS), .VPN2_W (VPN2_W), .MASK_W (MASK_W),
    .ASID_W    (ASID_W),    .GID_W  (GID_W),  .R_W    (R_W)
  ) u_lookup (
    .lk_vpn2 (lk_vpn2),
    .lk_r    (lk_r),
    .lk_asid (lk_asid),
    .lk_gid  (lk_gid),
    .st_vpn2 (st_vpn2),
    .st_mask (st_mask),
    .st_r    (st_r),
    .st_asid (st_asid),
    .st_gid  (st_gid),
    .st_g    (st_g),
    .st_live (st_live),
    .lk_hit  (lk_hit),
    .lk_idx  (lk_idx)
  );

  // ---------------------------------------------------------------- next state
  always_comb begin
    nx_vpn2 = st_vpn2;
    nx_mask = st_mask;
    nx_r    = st_r;
    nx_asid = st_asid;
    nx_gid  = st_gid;
    nx_g    = st_g;
    nx_hinv = st_hinv;
    nx_lo0  = st_lo0;
    nx_lo1  = st_lo1;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      if (dup[k]) begin
        nx_lo0[k][0] = 1'b0;
        nx_lo1[k][0] = 1'b0;
        nx_hinv[k]   = 1'b1;
      end
    end
    nx_vpn2[tgt] = f_vpn2;
    nx_mask[tgt] = f_mask;
    nx_r[tgt]    = f_r;
    nx_asid[tgt] = f_asid;
    nx_gid[tgt]  = f_gid;
    nx_g[tgt]    = f_g;
    nx_hinv[tgt] = f_hinv;
    nx_lo0[tgt]  = f_lo0;
    nx_lo1[tgt]  = f_lo1;
  end

  // ---------------------------------------------------------------- registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_vpn2 <= '0;
      st_mask <= '0;
      st_r    <= '0;
      st_asid <= '0;
      st_gid  <= '0;
      st_g    <= '0;
      st_hinv <= '0;
      st_lo0  <= '0;
      st_lo1  <= '0;
    end else if (wr_go) begin
      st_vpn2 <= nx_vpn2;
      st_mask <= nx_mask;
      st_r    <= nx_r;
      st_asid <= nx_asid;
      st_gid  <= nx_gid;
      st_g    <= nx_g;
      st_hinv <= nx_hinv;
      st_lo0  <= nx_lo0;
      st_lo1  <= nx_lo1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      exc_q  <= EXC_NONE;
    end else begin
      done_q <= wr_go;
      exc_q  <= exc_nx;
    end
  end

  // ---------------------------------------------------------------- outputs
  assign wr_done   = done_q;
  assign exc_valid = (exc_q != EXC_NONE);
  assign exc_code  = exc_q;

  assign rd_vpn2 = st_vpn2[rd_idx];
  assign rd_mask = st_mask[rd_idx];
  assign rd_r    = st_r[rd_idx];
  assign rd_asid = st_asid[rd_idx];
  assign rd_gid  = st_gid[rd_idx];
  assign rd_g    = st_g[rd_idx];
  assign rd_hinv = st_hinv[rd_idx];
  assign rd_lo0  = st_lo0[rd_idx];
  assign rd_lo1  = st_lo1[rd_idx];

  // ---------------------------------------------------------------- assertions
  p_cpu_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !cp0_en) |=> (exc_valid && exc_code == 2'd1 && !wr_done));

  p_ri_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && cp0_en && guest_kernel) |=> (exc_valid && exc_code == 2'd2 && !wr_done));

  p_exc_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> ($stable(st_lo0) && $stable(st_lo1) && $stable(st_vpn2) && $stable(st_hinv)));

  p_done_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && cp0_en && !guest_kernel) |=> (wr_done && !exc_valid));

  p_done_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_done && exc_valid));

  p_g_and_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> (st_g[$past(tgt)] == $past(elo0[0] && elo1[0])));

  p_vpn2_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> ((st_vpn2[$past(tgt)][MASK_W-1:0] & $past(pmask)) == '0));

  p_tgt_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && (elo0[1] || elo1[1]) && !(inv_level >= INV_LVL_HW && ehi_hinv) && !st_hinv[tgt])
      |=> st_live[$past(tgt)]);

endmodule

// File: tb/gtlb_rand_wr_bench.sv
`timescale 1ns/1ps
module gtlb_rand_wr_bench;

  logic        clk;
  logic        rst_n;
  logic        wr_req, cp0_en, guest_kernel, ehi_hinv, gid_en;
  logic [1:0]  inv_level;
  logic [2:0]  root_gid;
  logic [7:0]  ehi_vpn2;
  logic [1:0]  ehi_r;
  logic [3:0]  ehi_asid;
  logic [13:0] elo0, elo1;
  logic [3:0]  pmask;
  logic [2:0]  rand_idx;
  logic        wr_done, exc_valid;
  logic [1:0]  exc_code;
  logic [7:0]  lk_vpn2;
  logic [1:0]  lk_r;
  logic [3:0]  lk_asid;
  logic [2:0]  lk_gid;
  logic        lk_hit;
  logic [2:0]  lk_idx;
  logic [2:0]  rd_idx;
  logic [7:0]  rd_vpn2;
  logic [3:0]  rd_mask;
  logic [1:0]  rd_r;
  logic [3:0]  rd_asid;
  logic [2:0]  rd_gid;
  logic        rd_g, rd_hinv;
  logic [12:0] rd_lo0, rd_lo1;

  int n_chk  = 0;
  int n_fail = 0;

  gtlb_rand_wr u_gtlb_rand_wr (
    .clk (clk), .rst_n (rst_n), .wr_req (wr_req), .cp0_en (cp0_en),
    .guest_kernel (guest_kernel), .inv_level (inv_level), .gid_en (gid_en),
    .root_gid (root_gid), .ehi_vpn2 (ehi_vpn2), .ehi_r (ehi_r),
    .ehi_asid (ehi_asid), .ehi_hinv (ehi_hinv), .elo0 (elo0), .elo1 (elo1),
    .pmask (pmask), .rand_idx (rand_idx), .wr_done (wr_done),
    .exc_valid (exc_valid), .exc_code (exc_code), .lk_vpn2 (lk_vpn2),
    .lk_r (lk_r), .lk_asid (lk_asid), .lk_gid (lk_gid), .lk_hit (lk_hit),
    .lk_idx (lk_idx), .rd_idx (rd_idx), .rd_vpn2 (rd_vpn2), .rd_mask (rd_mask),
    .rd_r (rd_r), .rd_asid (rd_asid), .rd_gid (rd_gid), .rd_g (rd_g),
    .rd_hinv (rd_hinv), .rd_lo0 (rd_lo0), .rd_lo1 (rd_lo1)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk);
    wr_req = 1'b1;
    @(negedge clk);
    wr_req = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Simple entry: both halves share PFN 0, C 0, D 0, V0 = 1, V1 = 0.
  task automatic wr_simple(input logic [2:0] idx, input logic [7:0] vpn,
                           input logic [3:0] msk, input logic [1:0] r,
                           input logic [3:0] asid, input logic g);
    rand_idx = idx; ehi_vpn2 = vpn; pmask = msk; ehi_r = r; ehi_asid = asid;
    elo0 = {8'h00, 3'd0, 1'b0, 1'b1, g};
    elo1 = {8'h00, 3'd0, 1'b0, 1'b0, g};
    strobe();
  endtask

  task automatic probe(input string tag, input logic [7:0] vpn, input logic [1:0] r,
                       input logic [3:0] asid, input logic hit, input logic [2:0] idx);
    lk_vpn2 = vpn; lk_r = r; lk_asid = asid; lk_gid = 3'd0;
    #1;
    chk({tag, " hit"}, 32'(lk_hit), 32'(hit));
    if (hit) chk({tag, " idx"}, 32'(lk_idx), 32'(idx));
  endtask

  task automatic read_slot(input logic [2:0] idx);
    rd_idx = idx;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0]  v, m8, snap_vpn;
    logic [2:0]  i3, tgt, prev_gid;
    logic [3:0]  m4;
    logic [12:0] snap_lo;
    logic        prev_hinv;

    wr_req = 0; cp0_en = 1; guest_kernel = 0; inv_level = 0; gid_en = 0;
    root_gid = 0; ehi_vpn2 = 0; ehi_r = 0; ehi_asid = 0; ehi_hinv = 0;
    elo0 = 0; elo1 = 0; pmask = 0; rand_idx = 0;
    lk_vpn2 = 0; lk_r = 0; lk_asid = 0; lk_gid = 0; rd_idx = 0;

    do_reset();

    // R12: reset state
    chk("R12 done", 32'(wr_done), 0);
    chk("R12 exc", 32'(exc_valid), 0);
    probe("R12 probe", 8'h00, 2'd0, 4'd0, 1'b0, 3'd0);
    for (int s = 0; s < 8; s++) begin
      read_slot(3'(s));
      chk("R12 slot", {rd_vpn2, rd_mask, rd_r, rd_asid, rd_gid, rd_g, rd_hinv}, 0);
      chk("R12 halves", {6'd0, rd_lo0, rd_lo1}, 0);
    end

    // R1 R2 R3 R4: every index against every page mask
    for (int idx = 0; idx < 8; idx++) begin
      for (int m = 0; m < 16; m++) begin
        i3 = idx[2:0];
        m4 = m[3:0];
        v  = 8'(idx * 37 + m * 11);
        m8 = {4'd0, m4};
        rand_idx = i3; pmask = m4; ehi_vpn2 = v; ehi_r = i3[1:0]; ehi_asid = m4;
        elo0 = {v ^ 8'h5A, m4[2:0], i3[0], 1'b1, m4[2]};
        elo1 = {v ^ 8'hC3, i3, m4[0], m4[1], m4[3]};
        strobe();
        chk("R10 done", 32'(wr_done), 1);
        tgt = (m4 == 4'd0) ? i3 : {1'b0, i3[1:0]};
        read_slot(tgt);
        chk("R1 R3 vpn2 at slot", 32'(rd_vpn2), 32'(v & ~m8));
        chk("R4 mask", 32'(rd_mask), 32'(m4));
        chk("R4 region", 32'(rd_r), 32'(i3[1:0]));
        chk("R4 asid", 32'(rd_asid), 32'(m4));
        chk("R2 global", 32'(rd_g), 32'(m4[2] & m4[3]));
        chk("R3 R4 half0", 32'(rd_lo0), 32'({(v ^ 8'h5A) & ~m8, m4[2:0], i3[0], 1'b1}));
        chk("R3 R4 half1", 32'(rd_lo1), 32'({(v ^ 8'hC3) & ~m8, i3, m4[0], m4[1]}));
      end
    end

    // R10: pulse lasts one cycle
    @(negedge clk);
    chk("R10 done drops", 32'(wr_done), 0);

    // R5: hardware-invalid flag per invalidate-support level
    read_slot(3'd6);
    prev_hinv = rd_hinv;
    for (int lvl = 0; lvl < 4; lvl++) begin
      for (int h = 0; h < 2; h++) begin
        inv_level = 2'(lvl); ehi_hinv = h[0];
        wr_simple(3'd6, 8'hE6, 4'd0, 2'd3, 4'd6, 1'b0);
        read_slot(3'd6);
        if (lvl >= 2) prev_hinv = h[0];
        chk("R5 hinv", 32'(rd_hinv), 32'(prev_hinv));
      end
    end
    // keep slot 6 flagged, then write at level 0: flag must stay
    inv_level = 2'd3; ehi_hinv = 1'b1;
    wr_simple(3'd6, 8'hE6, 4'd0, 2'd3, 4'd6, 1'b0);
    inv_level = 2'd0; ehi_hinv = 1'b0;
    wr_simple(3'd6, 8'hE6, 4'd0, 2'd3, 4'd6, 1'b0);
    read_slot(3'd6);
    chk("R5 hinv kept", 32'(rd_hinv), 1);

    // R6: guest ID storage
    read_slot(3'd3);
    prev_gid = rd_gid;
    for (int e = 0; e < 2; e++) begin
      for (int g = 0; g < 8; g++) begin
        gid_en = e[0]; root_gid = 3'(g);
        wr_simple(3'd3, 8'h33, 4'd0, 2'd0, 4'd1, 1'b0);
        read_slot(3'd3);
        if (e == 1) prev_gid = 3'(g);
        chk("R6 gid", 32'(rd_gid), 32'(prev_gid));
      end
    end
    gid_en = 1'b0;

    // R7 R8: enable and privilege checks
    for (int c = 0; c < 2; c++) begin
      for (int k = 0; k < 2; k++) begin
        read_slot(3'd1);
        snap_vpn = rd_vpn2; snap_lo = rd_lo0;
        cp0_en = c[0]; guest_kernel = k[0];
        wr_simple(3'd1, snap_vpn + 8'd1, 4'd0, 2'd2, 4'd9, 1'b0);
        read_slot(3'd1);
        if (c == 0) begin
          chk("R7 exc", 32'(exc_valid), 1);
          chk("R7 code", 32'(exc_code), 1);
          chk("R7 no done", 32'(wr_done), 0);
          chk("R7 vpn2 kept", 32'(rd_vpn2), 32'(snap_vpn));
          chk("R7 half kept", 32'(rd_lo0), 32'(snap_lo));
        end else if (k == 1) begin
          chk("R8 exc", 32'(exc_valid), 1);
          chk("R8 code", 32'(exc_code), 2);
          chk("R8 no done", 32'(wr_done), 0);
          chk("R8 vpn2 kept", 32'(rd_vpn2), 32'(snap_vpn));
        end else begin
          chk("R10 code zero", 32'({exc_valid, exc_code}), 0);
          chk("R10 done", 32'(wr_done), 1);
          chk("R4 vpn2 new", 32'(rd_vpn2), 32'(snap_vpn + 8'd1));
        end
        @(negedge clk);
        chk("R10 exc drops", 32'({exc_valid, wr_done}), 0);
      end
    end
    cp0_en = 1'b1; guest_kernel = 1'b0;

    // R9 R11: duplicate invalidation and probing from a clean buffer
    do_reset();
    wr_simple(3'd2, 8'h50, 4'd0, 2'd1, 4'd3, 1'b0);
    probe("R11 first", 8'h50, 2'd1, 4'd3, 1'b1, 3'd2);
    probe("R11 miss", 8'h77, 2'd1, 4'd3, 1'b0, 3'd0);
    wr_simple(3'd5, 8'h50, 4'd0, 2'd1, 4'd3, 1'b0);
    chk("R9 no exc", 32'(exc_valid), 0);
    chk("R9 done", 32'(wr_done), 1);
    read_slot(3'd2);
    chk("R9 old V cleared", 32'(rd_lo0[0]), 0);
    chk("R9 old hinv set", 32'(rd_hinv), 1);
    probe("R11 moved", 8'h50, 2'd1, 4'd3, 1'b1, 3'd5);
    // different ASID, not global: no duplicate
    wr_simple(3'd7, 8'h50, 4'd0, 2'd1, 4'd4, 1'b0);
    read_slot(3'd5);
    chk("R9 other asid kept", 32'(rd_lo0[0]), 1);
    probe("R11 asid3", 8'h50, 2'd1, 4'd3, 1'b1, 3'd5);
    probe("R11 asid4", 8'h50, 2'd1, 4'd4, 1'b1, 3'd7);
    // global new entry removes both
    wr_simple(3'd0, 8'h50, 4'd0, 2'd1, 4'd9, 1'b1);
    read_slot(3'd5);
    chk("R9 global clears 5", 32'(rd_lo0[0]), 0);
    read_slot(3'd7);
    chk("R9 global clears 7", 32'(rd_lo0[0]), 0);
    probe("R11 global", 8'h50, 2'd1, 4'd3, 1'b1, 3'd0);
    // masked entry overlapping slot 0 (non-zero mask lands in slot rand_idx mod 4)
    wr_simple(3'd5, 8'h53, 4'h3, 2'd1, 4'd9, 1'b0);
    read_slot(3'd0);
    chk("R9 mask overlap clears 0", 32'(rd_lo0[0]), 0);
    read_slot(3'd1);
    chk("R1 R3 split slot vpn2", 32'(rd_vpn2), 32'h50);
    probe("R11 masked", 8'h52, 2'd1, 4'd9, 1'b1, 3'd1);
    // different region: no duplicate
    wr_simple(3'd3, 8'h50, 4'd0, 2'd2, 4'd9, 1'b0);
    read_slot(3'd1);
    chk("R9 region kept", 32'(rd_lo0[0]), 1);
    // rewrite the same slot with the same entry: target is never its own duplicate
    wr_simple(3'd3, 8'h50, 4'd0, 2'd2, 4'd9, 1'b0);
    read_slot(3'd3);
    chk("R9 target live", 32'({rd_lo0[0], rd_hinv}), 32'b10);
    probe("R11 region2", 8'h50, 2'd2, 4'd9, 1'b1, 3'd3);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule